// File: doc/BRIEF.md
# Trim DAC Serial Loader

This block writes one 8-bit setting into one of 21 trim DAC channels. The channels sit on three serially loaded converter chips, and each chip has eight channels. The host gives a channel number and a value together with a one-cycle start pulse. The block builds an 11-bit word from the low three bits of the channel (the sub-address inside a chip) and the value. It shifts that word out on a data line and a clock line, most significant bit first.

After the last bit, the block drives a two-bit load code that names the chip: code 1 picks chip 0, code 2 picks chip 1 and code 3 picks chip 2. The code is then cleared to zero and the block reports completion. The chip is chosen by that load code alone. No select is held while the word is shifting.

Each clock phase lasts a fixed number of system clocks, set by a parameter. A channel number above 20 is refused with an error pulse and causes no activity on the serial lines.

Top module: `trimdac_loader`

## Requirements
- R1: The shifted word is 11 bits: bits 10:8 hold the channel number modulo 8 and bits 7:0 hold the value.
- R2: Bits leave most significant first, one bit for each rising edge of the serial clock, with exactly 11 rising edges per load.
- R3: The data line takes each new bit while the serial clock is low, and it holds that bit for the whole high phase.
- R4: After the 11th bit, the load lines carry the code (channel / 8) + 1, hold it steady, and then return to 0.
- R5: A start with a channel of 21 to 31 gives a one-cycle error pulse in the next cycle, no busy, and no clock, data or load activity.
- R6: Every phase (clock low, clock high, the settle phase and the load strobe) lasts PHASE_CLKS cycles. Busy is therefore high for 24 × PHASE_CLKS cycles, starting in the cycle after the accepted start.
- R7: A start pulse that arrives while busy is ignored. The load in progress shifts its own word and load code unchanged.
- R8: The serial clock is low whenever the load lines are non-zero, and the load lines are zero whenever busy is low.
- R9: Done is a one-cycle pulse, raised in the cycle in which busy falls and the load lines clear.
- R10: While reset is active and after it is released, the clock, data, load, busy, done and error outputs are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start_i | input | 1 | One-cycle request to load a channel |
| chan_i | input | 5 | Trim channel number, 0 to 20 valid |
| value_i | input | 8 | Setting for the channel |
| sdata_o | output | 1 | Serial data line |
| sclk_o | output | 1 | Serial clock line |
| load_o | output | 2 | Chip load code, 0 when idle |
| busy_o | output | 1 | A load is in progress |
| done_o | output | 1 | One-cycle pulse when a load completes |
| err_o | output | 1 | One-cycle pulse when a channel number is refused |

## Verification
The assertions assume that the host changes `chan_i` and `value_i` only as part of a start pulse. They also assume that no start arrives during reset or during the two-cycle reset release. The stimulus keeps to this: it drives every input on the falling clock edge, holds start high for exactly one cycle, and waits for done or for the error pulse before it begins the next request. The exception is the deliberate start placed in the middle of a transfer, which tests that the block ignores it. The sweep covers every valid channel and every invalid channel number. It uses data values computed from the channel, together with the all-zero and all-one patterns.

// File: rtl/trimdac_pkg.sv
package trimdac_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SETUP  = 3'd1,
    ST_HIGH   = 3'd2,
    ST_SETTLE = 3'd3,
    ST_STROBE = 3'd4
  } seq_st_e;

  // Number of phases a complete load spends busy: two per bit, plus settle and strobe.
  function automatic int unsigned phases_per_load(input int unsigned word_bits);
    return 2 * word_bits + 2;
  endfunction

endpackage

// File: rtl/trimdac_req.sv
// Checks the request, then captures the serial word and the chip load code.
module trimdac_req #(
  parameter int unsigned NUM_CH      = 21,
  parameter int unsigned CH_PER_CHIP = 8,
  parameter int unsigned VAL_W       = 8,
  parameter int unsigned CHAN_W      = 5,
  parameter int unsigned SUB_W       = 3,
  parameter int unsigned SEL_W       = 2,
  localparam int unsigned WORD_W     = SUB_W + VAL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept_i,
  input  logic [CHAN_W-1:0] chan_i,
  input  logic [VAL_W-1:0]  value_i,
  output logic              valid_o,
  output logic [WORD_W-1:0] word_o,
  output logic [SEL_W-1:0]  code_o
);

  logic [CHAN_W-1:0] chip_idx;
  logic [SUB_W-1:0]  sub_addr;
  logic [WORD_W-1:0] word_d, word_q;
  logic [SEL_W-1:0]  code_d, code_q;

  always_comb begin
    valid_o  = (32'(chan_i) < NUM_CH);
    chip_idx = chan_i / CHAN_W'(CH_PER_CHIP);
    sub_addr = chan_i[SUB_W-1:0];
    word_d   = {sub_addr, value_i};
    code_d   = SEL_W'(chip_idx + CHAN_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      code_q <= '0;
    end else if (accept_i) begin
      word_q <= word_d;
      code_q <= code_d;
    end
  end

  assign word_o = word_q;
  assign code_o = code_q;

endmodule

// File: rtl/trimdac_timer.sv
// Counts the system clocks inside one phase and flags the last one.
module trimdac_timer #(
  parameter int unsigned PHASE_CLKS = 2,
  localparam int unsigned CNT_W     = $clog2(PHASE_CLKS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic phase_end_o
);

  logic [CNT_W-1:0] cnt_d, cnt_q;

  always_comb begin
    phase_end_o = run_i && (cnt_q == CNT_W'(PHASE_CLKS - 1));
    if (!run_i || phase_end_o) cnt_d = '0;
    else                       cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/trimdac_seq.sv
// Steps through the bit phases, the settle phase and the load strobe.
module trimdac_seq
  import trimdac_pkg::*;
#(
  parameter int unsigned WORD_W = 11,
  parameter int unsigned SEL_W  = 2,
  localparam int unsigned BIT_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              valid_i,
  input  logic              phase_end_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [SEL_W-1:0]  code_i,
  output logic              accept_o,
  output logic              run_o,
  output logic              sdata_o,
  output logic              sclk_o,
  output logic [SEL_W-1:0]  load_o,
  output logic              done_o,
  output logic              err_o
);

  seq_st_e          st_d, st_q;
  logic [BIT_W-1:0] bit_d, bit_q;
  logic             done_d, done_q;
  logic             err_d, err_q;
  logic             idle;

  always_comb begin
    idle     = (st_q == ST_IDLE);
    accept_o = idle && start_i && valid_i;
    st_d     = st_q;
    bit_d    = bit_q;
    done_d   = 1'b0;
    err_d    = idle && start_i && !valid_i;
    case (st_q)
      ST_IDLE: begin
        if (accept_o) begin
          st_d  = ST_SETUP;
          bit_d = BIT_W'(WORD_W - 1);
        end
      end
      ST_SETUP: begin
        if (phase_end_i) st_d = ST_HIGH;
      end
      ST_HIGH: begin
        if (phase_end_i) begin
          if (bit_q == '0) begin
            st_d = ST_SETTLE;
          end else begin
            st_d  = ST_SETUP;
            bit_d = bit_q - BIT_W'(1);
          end
        end
      end
      ST_SETTLE: begin
        if (phase_end_i) st_d = ST_STROBE;
      end
      ST_STROBE: begin
        if (phase_end_i) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      bit_q  <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      bit_q  <= bit_d;
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  always_comb begin
    run_o   = !idle;
    sclk_o  = (st_q == ST_HIGH);
    sdata_o = ((st_q == ST_SETUP) || (st_q == ST_HIGH)) && word_i[bit_q];
    load_o  = (st_q == ST_STROBE) ? code_i : '0;
    done_o  = done_q;
    err_o   = err_q;
  end

endmodule

// File: rtl/trimdac_loader.sv
module trimdac_loader #(
  parameter int unsigned NUM_CH      = 21,
  parameter int unsigned CH_PER_CHIP = 8,
  parameter int unsigned VAL_W       = 8,
  parameter int unsigned PHASE_CLKS  = 2,
  localparam int unsigned NUM_CHIPS  = (NUM_CH + CH_PER_CHIP - 1) / CH_PER_CHIP,
  localparam int unsigned CHAN_W     = $clog2(NUM_CH),
  localparam int unsigned SUB_W      = $clog2(CH_PER_CHIP),
  localparam int unsigned SEL_W      = $clog2(NUM_CHIPS + 1),
  localparam int unsigned WORD_W     = SUB_W + VAL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [CHAN_W-1:0] chan_i,
  input  logic [VAL_W-1:0]  value_i,
  output logic              sdata_o,
  output logic              sclk_o,
  output logic [SEL_W-1:0]  load_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o
);

  // Reset is asserted asynchronously and released on a clock edge.
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  logic              req_valid;
  logic              accept;
  logic              run;
  logic              phase_end;
  logic [WORD_W-1:0] word_q;
  logic [SEL_W-1:0]  code_q;

  trimdac_req #(
    .NUM_CH(NUM_CH), .CH_PER_CHIP(CH_PER_CHIP), .VAL_W(VAL_W),
    .CHAN_W(CHAN_W), .SUB_W(SUB_W), .SEL_W(SEL_W)
  ) u_req (
    .clk(clk), .rst_n(rst_core_n), .accept_i(accept),
    .chan_i(chan_i), .value_i(value_i),
    .valid_o(req_valid), .word_o(word_q), .code_o(code_q)
  );

  trimdac_timer #(.PHASE_CLKS(PHASE_CLKS)) u_timer (
    .clk(clk), .rst_n(rst_core_n), .run_i(run), .phase_end_o(phase_end)
  );

  trimdac_seq #(.WORD_W(WORD_W), .SEL_W(SEL_W)) u_seq (
    .clk(clk), .rst_n(rst_core_n), .start_i(start_i), .valid_i(req_valid),
    .phase_end_i(phase_end), .word_i(word_q), .code_i(code_q),
    .accept_o(accept), .run_o(run), .sdata_o(sdata_o), .sclk_o(sclk_o),
    .load_o(load_o), .done_o(done_o), .err_o(err_o)
  );

  assign busy_o = run;

endmodule

// File: rtl/trimdac_loader_chk.sv
module trimdac_loader_chk #(
  parameter int unsigned PHASE_CLKS = 2,
  parameter int unsigned SEL_W      = 2,
  parameter int unsigned WORD_W     = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sdata,
  input logic              sclk,
  input logic [SEL_W-1:0]  load,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic [WORD_W-1:0] word
);

  logic [15:0] hi_run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    hi_run_q <= '0;
    else if (sclk) hi_run_q <= hi_run_q + 16'd1;
    else           hi_run_q <= '0;
  end

  p_data_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> $stable(sdata));

  p_clk_low_at_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (load != '0) |-> !sclk);

  p_load_needs_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (load != '0) |-> busy);

  p_load_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((load != '0) && $past(load != '0)) |-> $stable(load));

  p_err_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!busy && !sclk && (load == '0)));

  p_done_ends_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy) && (load == '0)));

  p_word_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(word));

  p_high_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> (hi_run_q < 16'(PHASE_CLKS)));

endmodule

bind trimdac_loader trimdac_loader_chk #(
  .PHASE_CLKS(PHASE_CLKS), .SEL_W(SEL_W), .WORD_W(WORD_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sdata(sdata_o), .sclk(sclk_o), .load(load_o),
  .busy(busy_o), .done(done_o), .err(err_o), .word(word_q)
);

// File: tb/sim_trimdac_loader.sv
module sim_trimdac_loader;

  localparam int P = 3;

  logic       clk;
  logic       rst_n;
  logic       start_i;
  logic [4:0] chan_i;
  logic [7:0] value_i;
  logic       sdata_o, sclk_o, busy_o, done_o, err_o;
  logic [1:0] load_o;

  int n_checks = 0;
  int n_fail   = 0;

  trimdac_loader #(.PHASE_CLKS(P)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .chan_i(chan_i),
    .value_i(value_i), .sdata_o(sdata_o), .sclk_o(sclk_o), .load_o(load_o),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  // Runs one load; if intr is set, a second start appears mid-transfer.
  task automatic do_load(input int ch, input int val, input bit intr);
    logic [10:0] got;
    int rises, busy_cyc, load_code, loads_seen, held_bad, clk_at_load, cyc;
    bit prev_sclk, prev_sdata, seen_done;
    got = '0; rises = 0; busy_cyc = 0; load_code = 0; loads_seen = 0;
    held_bad = 0; clk_at_load = 0; cyc = 0; seen_done = 0;
    prev_sclk = 0; prev_sdata = 0;
    @(negedge clk);
    start_i = 1'b1; chan_i = 5'(ch); value_i = 8'(val);
    @(negedge clk);
    start_i = 1'b0;
    while (!seen_done && cyc < 1000) begin
      if (busy_o) busy_cyc++;
      if (sclk_o && !prev_sclk) begin
        got = {got[9:0], sdata_o};
        rises++;
      end
      if (sclk_o && prev_sclk && (sdata_o != prev_sdata)) held_bad++;
      if (load_o != 2'd0) begin
        if (loads_seen == 0) load_code = int'(load_o);
        else if (int'(load_o) != load_code) held_bad++;
        loads_seen++;
        if (sclk_o) clk_at_load++;
      end
      if (done_o) begin
        seen_done = 1;
        check(!busy_o && load_o == 2'd0, "R9 done with busy low and load clear",
              {busy_o, load_o}, 0);
      end
      prev_sclk = sclk_o; prev_sdata = sdata_o;
      cyc++;
      if (intr && cyc == 10) begin
        start_i = 1'b1; chan_i = 5'((ch + 9) % 21); value_i = 8'(~val);
      end else begin
        start_i = 1'b0;
      end
      if (!seen_done) @(negedge clk);
    end
    start_i = 1'b0;
    check(got == {3'(ch % 8), 8'(val)}, intr ? "R7 word kept despite start" : "R1 word",
          int'(got), int'({3'(ch % 8), 8'(val)}));
    check(rises == 11, "R2 rising edge count", rises, 11);
    check(held_bad == 0, "R3 data held during high phase", held_bad, 0);
    check(load_code == ch / 8 + 1, "R4 load code", load_code, ch / 8 + 1);
    check(loads_seen == P, "R6 strobe length", loads_seen, P);
    check(clk_at_load == 0, "R8 clock low during strobe", clk_at_load, 0);
    check(busy_cyc == 24 * P, "R6 busy length", busy_cyc, 24 * P);
    @(negedge clk);
    check(!done_o && !busy_o && load_o == 2'd0, "R9 single done pulse",
          {done_o, busy_o, load_o}, 0);
  endtask

  task automatic bad_chan(input int ch);
    int act;
    @(negedge clk);
    start_i = 1'b1; chan_i = 5'(ch); value_i = 8'hA5;
    @(negedge clk);
    start_i = 1'b0;
    check(err_o && !busy_o, "R5 error pulse", {err_o, busy_o}, 2);
    act = 0;
    for (int k = 0; k < 2 * P + 2; k++) begin
      @(negedge clk);
      if (err_o || busy_o || sclk_o || sdata_o || load_o != 2'd0) act++;
    end
    check(act == 0, "R5 no activity after refusal", act, 0);
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; chan_i = '0; value_i = '0;
    repeat (3) @(negedge clk);
    check({sclk_o, sdata_o, load_o, busy_o, done_o, err_o} == 7'd0,
          "R10 outputs in reset", int'({sclk_o, sdata_o, load_o, busy_o, done_o, err_o}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check({sclk_o, sdata_o, load_o, busy_o, done_o, err_o} == 7'd0,
          "R10 outputs after release", int'({sclk_o, sdata_o, load_o, busy_o, done_o, err_o}), 0);
    for (int ch = 0; ch < 21; ch++) do_load(ch, (ch * 37 + 5) % 256, 1'b0);
    do_load(0, 8'hFF, 1'b0);
    do_load(20, 8'h00, 1'b0);
    do_load(7, 8'h80, 1'b0);
    do_load(8, 8'h01, 1'b0);
    do_load(13, 8'h5A, 1'b1);
    do_load(2, 8'hC3, 1'b1);
    for (int ch = 21; ch < 32; ch++) bad_chan(ch);
    do_load(16, 8'h3C, 1'b0);
    finish_run();
  end

endmodule